// File: doc/BRIEF.md
# Event Timer Register Front-End

This block is the register front-end of an eight-timer event block. A host issues single-cycle requests carrying a byte offset, an access size and, for writes, a 64-bit data word. The block decodes the request into a fixed identity word, a global control register, an interrupt status register, a main count register and three registers per timer: control, compare value and message route. It answers every read one cycle later on a registered data bus.

Each register is 64 bits wide. A 4-byte access reaches either half of a register. A write passes through a lane mask, so it changes only the addressed half and only the fields that software may change. The fields that describe what a timer can do stay fixed. Accesses that break the size or alignment rules, and offsets that map to nothing, are ignored on write and read back as zero.

The comparator and interrupt engines sit outside this block. They see a run level, one-cycle start and stop pulses, a per-timer compare-write strobe and the status bits. They set status bits through a set vector.

Top module: `tr_regif`

## Requirements
- R1: Only request sizes of 4 and 8 bytes are accepted. A write of any other size changes no register and raises no strobe, and a read of any other size returns zero.
- R2: An 8-byte access needs offset bits 2:0 equal to zero and a 4-byte access needs offset bits 1:0 equal to zero. A misaligned write is ignored and a misaligned read returns zero.
- R3: A 4-byte access with offset bit 2 set reaches bits 63:32 of the register: write data is taken from wdata bits 31:0 into the upper half, and read data is returned in bits 31:0. A 4-byte access with bit 2 clear reaches bits 31:0. A 4-byte read always returns zero in bits 63:32, and a 4-byte write leaves the other half unchanged.
- R4: Offset 0x000 reads the constant 0x05F5E100_80868701. This word holds revision 1 in bits 7:0, the timer count minus one in bits 12:8, a clear count-width bit 13, a set routing-capable bit 15, the value 0x8086 in bits 31:16 and a 100,000,000 fs tick period in bits 63:32. Writes to this offset have no effect.
- R5: The global control register at 0x010 has writable bits 1:0 and all other bits read zero. run_en follows bit 0. A write that sets bit 0 from 0 to 1 pulses run_start for one cycle, one that clears it pulses run_stop, and a write that keeps bit 0 unchanged pulses neither.
- R6: The status register at 0x020 holds one bit per timer in bits 7:0 and drives sts_out. A set bit in sts_set sets the matching status bit on the next edge. A write clears exactly the bits that are written as one and are currently set. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: The control register of timer n is at 0x100+0x20·n. It resets to 0x8010, so the message-capable bit 15 and the periodic-capable bit 4 are set and the route-allowed mask in bits 63:32 is zero. Writes change only bits 14:9, 6, 3, 2 and 1 (mask 0x7E4E). Bit 8 always reads zero.
- R8: The comparator of timer n is at 0x108+0x20·n. It is 32 bits wide, resets to 0xFFFFFFFF and reads zero in bits 63:32. Every accepted write to it, including a write to its upper half, pulses bit n of cmp_wr_stb for one cycle on the next edge.
- R9: The message route of timer n is at 0x110+0x20·n. It is a fully writable 64-bit register that resets to zero.
- R10: The main count register at 0x0F0 is 32 bits wide, is writable and resets to zero. Bits 63:32 read zero.
- R11: Any other offset reads zero, including 0x118+0x20·n and every offset from 0x200 upward. Writes to such offsets change nothing.
- R12: rsp_rdata updates on the clock edge that accepts a read and holds its value in every cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 4 | Access size in bytes |
| req_addr | input | 12 | Byte offset |
| req_wdata | input | 64 | Write data, low-aligned for 4-byte writes |
| sts_set | input | 8 | Status set requests from the timers |
| rsp_rdata | output | 64 | Registered read data |
| run_en | output | 1 | Global run level |
| run_start | output | 1 | One-cycle pulse when run turns on |
| run_stop | output | 1 | One-cycle pulse when run turns off |
| sts_out | output | 8 | Current status bits |
| cmp_wr_stb | output | 8 | Per-timer compare-write pulse |

## Verification
A wrong lane mask or a wrong half select changes the other half of a register or a protected capability field. This shows up on the first read of that register, one cycle after the read is issued. A decode fault on a control write shows on the run level and the start and stop pulses on the very next edge, and a compare write shows on the strobe vector in the same way. A status bit that is cleared when it should survive, or kept when it should clear, is visible on sts_out one edge after the offending write. The bench model compares every output on every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/tr_pkg.sv
package tr_pkg;
  localparam logic [63:0] CAP_WORD    = 64'h05F5_E100_8086_8701;
  localparam logic [63:0] GCFG_WMASK  = 64'h3;
  localparam logic [63:0] TCFG_WMASK  = 64'h7E4E;
  localparam logic [63:0] TCFG_RESET  = 64'h8010;
  localparam logic [31:0] CMP_RESET   = 32'hFFFF_FFFF;
  localparam logic [11:0] OFF_CAP     = 12'h000;
  localparam logic [11:0] OFF_GCFG    = 12'h010;
  localparam logic [11:0] OFF_STS     = 12'h020;
  localparam logic [11:0] OFF_CNT     = 12'h0F0;
  localparam logic [11:0] OFF_TBASE   = 12'h100;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CAP, SEL_GCFG, SEL_STS, SEL_CNT, SEL_TCFG, SEL_TCMP, SEL_TROUTE
  } sel_e;

  // Byte-lane mask of the addressed half (or whole word).
  function automatic logic [63:0] lane_mask(input logic narrow, input logic upper);
    if (!narrow) return '1;
    return upper ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
  endfunction

  // Moves low-aligned narrow write data into the addressed half.
  function automatic logic [63:0] steer_wr(input logic [63:0] d, input logic narrow,
                                           input logic upper);
    return (narrow && upper) ? {d[31:0], 32'h0} : d;
  endfunction

  // Replace masked bits of old with data.
  function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] d,
                                        input logic [63:0] m);
    return (old & ~m) | (d & m);
  endfunction

  // Narrow reads return the addressed half in the low bits.
  function automatic logic [63:0] steer_rd(input logic [63:0] d, input logic narrow,
                                           input logic upper);
    if (!narrow) return d;
    return {32'h0, upper ? d[63:32] : d[31:0]};
  endfunction
endpackage

// File: rtl/tr_decode.sv
module tr_decode
  import tr_pkg::*;
#(
  parameter int AW = 12,
  parameter int NT = 8,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [AW-1:0] addr,
  input  logic [3:0]    size,
  output logic          acc_ok,
  output logic          narrow,
  output logic          upper,
  output sel_e          sel,
  output logic [TW-1:0] tidx
);
  localparam logic [AW-1:0] TSPAN = AW'(NT * 32);

  logic [AW-1:0] base;
  logic [AW-1:0] toff;

  always_comb begin
    narrow = (size == 4'd4);
    upper  = narrow & addr[2];
    acc_ok = (size == 4'd8 && addr[2:0] == 3'b0) || (narrow && addr[1:0] == 2'b0);
    base   = {addr[AW-1:3], 3'b000};
    toff   = base - AW'(OFF_TBASE);
    tidx   = toff[5 +: TW];
    sel    = SEL_NONE;
    if (base == AW'(OFF_CAP))       sel = SEL_CAP;
    else if (base == AW'(OFF_GCFG)) sel = SEL_GCFG;
    else if (base == AW'(OFF_STS))  sel = SEL_STS;
    else if (base == AW'(OFF_CNT))  sel = SEL_CNT;
    else if (base >= AW'(OFF_TBASE) && toff < TSPAN) begin
      case (toff[4:3])
        2'd0:    sel = SEL_TCFG;
        2'd1:    sel = SEL_TCMP;
        2'd2:    sel = SEL_TROUTE;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tr_timer_bank.sv
module tr_timer_bank
  import tr_pkg::*;
#(
  parameter int NT = 8,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  sel_e          sel,
  input  logic [TW-1:0] tidx,
  input  logic [63:0]   wdata,
  input  logic [63:0]   wmask,
  output logic [63:0]   rd_word,
  output logic [NT-1:0] cmp_wr_stb
);
  logic [63:0] cfg_q   [NT];
  logic [31:0] cmp_q   [NT];
  logic [63:0] route_q [NT];

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    logic hit;
    logic [63:0] cmp_next;
    assign hit      = wr_go && (int'(tidx) == g);
    assign cmp_next = merge({32'h0, cmp_q[g]}, wdata, wmask);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[g]      <= TCFG_RESET;
        cmp_q[g]      <= CMP_RESET;
        route_q[g]    <= '0;
        cmp_wr_stb[g] <= 1'b0;
      end else begin
        cmp_wr_stb[g] <= hit && sel == SEL_TCMP;
        if (hit && sel == SEL_TCFG)   cfg_q[g]   <= merge(cfg_q[g], wdata, wmask & TCFG_WMASK);
        if (hit && sel == SEL_TCMP)   cmp_q[g]   <= cmp_next[31:0];
        if (hit && sel == SEL_TROUTE) route_q[g] <= merge(route_q[g], wdata, wmask);
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (int'(tidx) < NT) begin
      case (sel)
        SEL_TCFG:   rd_word = cfg_q[tidx];
        SEL_TCMP:   rd_word = {32'h0, cmp_q[tidx]};
        SEL_TROUTE: rd_word = route_q[tidx];
        default:    rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/tr_regif.sv
module tr_regif
  import tr_pkg::*;
#(
  parameter int AW = 12,
  parameter int NT = 8,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [3:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [63:0]   req_wdata,
  input  logic [NT-1:0] sts_set,
  output logic [63:0]   rsp_rdata,
  output logic          run_en,
  output logic          run_start,
  output logic          run_stop,
  output logic [NT-1:0] sts_out,
  output logic [NT-1:0] cmp_wr_stb
);
  logic          acc_ok, narrow, upper;
  sel_e          sel;
  logic [TW-1:0] tidx;
  logic [63:0]   wmask, wdata, bank_rd, rd_word, gcfg_next, cnt_next;
  logic          wr_go, rd_go;
  logic [63:0]   gcfg_q;
  logic [31:0]   cnt_q;
  logic [NT-1:0] sts_q, sts_clr;

  tr_decode #(.AW(AW), .NT(NT)) u_dec (
    .addr(req_addr), .size(req_size), .acc_ok(acc_ok), .narrow(narrow),
    .upper(upper), .sel(sel), .tidx(tidx)
  );

  assign wr_go = req_valid && req_write && acc_ok;
  assign rd_go = req_valid && !req_write;
  assign wmask = lane_mask(narrow, upper);
  assign wdata = steer_wr(req_wdata, narrow, upper);

  tr_timer_bank #(.NT(NT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .sel(sel), .tidx(tidx),
    .wdata(wdata), .wmask(wmask), .rd_word(bank_rd), .cmp_wr_stb(cmp_wr_stb)
  );

  assign gcfg_next = merge(gcfg_q, wdata, wmask & GCFG_WMASK);
  assign cnt_next  = merge({32'h0, cnt_q}, wdata, wmask);
  assign sts_clr   = (wr_go && sel == SEL_STS) ? (sts_q & wdata[NT-1:0] & wmask[NT-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg_q    <= '0;
      cnt_q     <= '0;
      sts_q     <= '0;
      run_start <= 1'b0;
      run_stop  <= 1'b0;
    end else begin
      run_start <= 1'b0;
      run_stop  <= 1'b0;
      sts_q     <= (sts_q & ~sts_clr) | sts_set;
      if (wr_go && sel == SEL_GCFG) begin
        gcfg_q    <= gcfg_next;
        run_start <= gcfg_next[0] & ~gcfg_q[0];
        run_stop  <= ~gcfg_next[0] & gcfg_q[0];
      end
      if (wr_go && sel == SEL_CNT) cnt_q <= cnt_next[31:0];
    end
  end

  always_comb begin
    case (sel)
      SEL_CAP:  rd_word = CAP_WORD;
      SEL_GCFG: rd_word = gcfg_q;
      SEL_STS:  rd_word = 64'(sts_q);
      SEL_CNT:  rd_word = {32'h0, cnt_q};
      default:  rd_word = bank_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_rdata <= '0;
    else if (rd_go) rsp_rdata <= acc_ok ? steer_rd(rd_word, narrow, upper) : '0;
  end

  assign run_en  = gcfg_q[0];
  assign sts_out = sts_q;
endmodule

// File: rtl/tr_regif_chk.sv
module tr_regif_chk #(
  parameter int AW = 12,
  parameter int NT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [3:0]    req_size,
  input logic [AW-1:0] req_addr,
  input logic [NT-1:0] sts_set,
  input logic [63:0]   rsp_rdata,
  input logic          run_en,
  input logic          run_start,
  input logic          run_stop,
  input logic [NT-1:0] sts_out,
  input logic [NT-1:0] cmp_wr_stb
);
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_start && run_stop)); // R5
  AST_RUN_ROSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> run_start); // R5
  AST_STOP_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    run_stop |-> !run_en); // R5
  AST_STS_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_set != '0) |=> ((sts_out & $past(sts_set)) == $past(sts_set))); // R6
  AST_CMP_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_wr_stb)); // R8
  AST_BAD_SIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_size != 4'd4 && req_size != 4'd8)
    |=> (cmp_wr_stb == '0 && !run_start && !run_stop)); // R1
  AST_CAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 4'd8 && req_addr == '0)
    |=> rsp_rdata == 64'h05F5_E100_8086_8701); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata)); // R12
endmodule

bind tr_regif tr_regif_chk #(.AW(AW), .NT(NT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .sts_set(sts_set),
  .rsp_rdata(rsp_rdata), .run_en(run_en), .run_start(run_start),
  .run_stop(run_stop), .sts_out(sts_out), .cmp_wr_stb(cmp_wr_stb)
);

// File: tb/test_tr_regif.sv
module test_tr_regif;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [3:0]  req_size = 0;
  logic [11:0] req_addr = 0;
  logic [63:0] req_wdata = 0;
  logic [7:0]  sts_set = 0;
  logic [63:0] rsp_rdata;
  logic        run_en, run_start, run_stop;
  logic [7:0]  sts_out, cmp_wr_stb;

  int compared = 0, mismatched = 0;
  string cur_req = "R12";

  tr_regif i_tr_regif (.*);

  always #10 clk = ~clk;

  // Behavioural reference state
  longint unsigned m_gcfg, m_cnt, m_rd;
  longint unsigned m_tcfg [8], m_cmp [8], m_route [8];
  bit [7:0] m_sts, m_stb;
  bit m_start, m_stop;

  function automatic longint unsigned model_read(int off);
    int n, sub;
    if (off == 0)   return 64'h05F5E100_80868701;
    if (off == 16)  return m_gcfg;
    if (off == 32)  return 64'(m_sts);
    if (off == 240) return m_cnt;
    if (off < 256 || off >= 512) return 0;
    n = (off - 256) / 32; sub = ((off - 256) % 32) / 8;
    if (sub == 0) return m_tcfg[n];
    if (sub == 1) return m_cmp[n];
    if (sub == 2) return m_route[n];
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gcfg = 0; m_cnt = 0; m_rd = 0; m_sts = 0; m_stb = 0; m_start = 0; m_stop = 0;
      for (int i = 0; i < 8; i++) begin
        m_tcfg[i] = 64'h8010; m_cmp[i] = 64'hFFFFFFFF; m_route[i] = 0;
      end
    end else begin
      bit ok, hi;
      int off, n, sub;
      longint unsigned wd, wm, v;
      bit [7:0] clr;
      m_start = 0; m_stop = 0; m_stb = 0; clr = 0;
      ok  = (req_size == 8 && req_addr[2:0] == 0) || (req_size == 4 && req_addr[1:0] == 0);
      hi  = (req_size == 4) && req_addr[2];
      off = int'(req_addr) & ~7;
      if (req_size == 8) begin wd = req_wdata; wm = '1; end
      else if (hi) begin wd = {req_wdata[31:0], 32'h0}; wm = 64'hFFFFFFFF_00000000; end
      else begin wd = {32'h0, req_wdata[31:0]}; wm = 64'h00000000_FFFFFFFF; end
      if (req_valid && !req_write) begin
        v = model_read(off);
        if (!ok) m_rd = 0;
        else if (req_size == 8) m_rd = v;
        else m_rd = hi ? (v >> 32) : (v & 64'hFFFFFFFF);
      end
      if (req_valid && req_write && ok) begin
        if (off == 16) begin
          v = (m_gcfg & ~(wm & 3)) | (wd & wm & 3);
          m_start = v[0] && !m_gcfg[0]; m_stop = !v[0] && m_gcfg[0]; m_gcfg = v;
        end else if (off == 32) clr = m_sts & wd[7:0] & wm[7:0];
        else if (off == 240) m_cnt = ((m_cnt & ~wm) | (wd & wm)) & 64'hFFFFFFFF;
        else if (off >= 256 && off < 512) begin
          n = (off - 256) / 32; sub = ((off - 256) % 32) / 8;
          if (sub == 0) m_tcfg[n] = (m_tcfg[n] & ~(wm & 64'h7E4E)) | (wd & wm & 64'h7E4E);
          if (sub == 1) begin m_cmp[n] = ((m_cmp[n] & ~wm) | (wd & wm)) & 64'hFFFFFFFF; m_stb[n] = 1; end
          if (sub == 2) m_route[n] = (m_route[n] & ~wm) | (wd & wm);
        end
      end
      m_sts = (m_sts & ~clr) | sts_set;
    end
  end

  task automatic cmp64(string what, longint unsigned act, longint unsigned exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp64("rsp_rdata", rsp_rdata, m_rd);
    cmp64("run_en", 64'(run_en), 64'(m_gcfg[0]));
    cmp64("run_start", 64'(run_start), 64'(m_start));
    cmp64("run_stop", 64'(run_stop), 64'(m_stop));
    cmp64("sts_out", 64'(sts_out), 64'(m_sts));
    cmp64("cmp_wr_stb", 64'(cmp_wr_stb), 64'(m_stb));
  end

  task automatic acc(bit wr, int sz, int addr, longint unsigned d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_size = 4'(sz); req_addr = 12'(addr); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic rd_expect(int sz, int addr, longint unsigned exp);
    acc(0, sz, addr, 0);
    cmp64("direct read", rsp_rdata, exp);
  endtask

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R4";  rd_expect(8, 12'h000, 64'h05F5E100_80868701);
    acc(1, 8, 12'h000, 0); rd_expect(4, 12'h004, 64'h05F5E100);
    cur_req = "R7";  rd_expect(8, 12'h100, 64'h8010);
    acc(1, 8, 12'h120, '1); rd_expect(8, 12'h120, 64'hFE5E);
    cur_req = "R8";  rd_expect(8, 12'h148, 64'hFFFFFFFF);
    acc(1, 4, 12'h168, 64'h1234); acc(1, 4, 12'h16C, 64'h55);
    rd_expect(8, 12'h168, 64'h1234);
    cur_req = "R9";  acc(1, 8, 12'h1F0, 64'hDEADBEEF_CAFEF00D);
    cur_req = "R3";  acc(1, 4, 12'h1F4, 64'h11112222); rd_expect(8, 12'h1F0, 64'h11112222_CAFEF00D);
    rd_expect(4, 12'h1F0, 64'hCAFEF00D);
    cur_req = "R10"; acc(1, 8, 12'h0F0, 64'hAAAA5555_00001234); rd_expect(8, 12'h0F0, 64'h1234);
    cur_req = "R5";  acc(1, 8, 12'h010, '1); rd_expect(8, 12'h010, 64'h3);
    acc(1, 4, 12'h010, 64'h3); acc(1, 4, 12'h010, 64'h2); acc(1, 4, 12'h010, 64'h1);
    cur_req = "R1";  acc(1, 2, 12'h010, 0); acc(1, 1, 12'h108, 5); rd_expect(2, 12'h010, 0);
    cur_req = "R2";  acc(1, 8, 12'h014, 0); acc(1, 4, 12'h10A, 7); rd_expect(8, 12'h104, 0);
    rd_expect(8, 12'h010, 64'h1);
    cur_req = "R6";
    @(negedge clk); sts_set = 8'hA5; @(negedge clk); sts_set = 0;
    acc(1, 8, 12'h020, 64'h0F); rd_expect(8, 12'h020, 64'hA0);
    @(negedge clk); req_valid = 1; req_write = 1; req_size = 8; req_addr = 12'h020;
    req_wdata = 64'hFF; sts_set = 8'h20; @(negedge clk); req_valid = 0; sts_set = 0;
    rd_expect(4, 12'h024, 0);
    cur_req = "R11"; acc(1, 8, 12'h118, '1); rd_expect(8, 12'h118, 0);
    rd_expect(8, 12'h200, 0); rd_expect(8, 12'h030, 0);
    cur_req = "R12"; repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule